// File: doc/BRIEF.md
# Reversible-LFSR Counting Bloom Filter

This block keeps one small counter per hash bucket for a counting Bloom filter and answers the question "is this bucket empty?". Each bucket is a local up/down linear feedback shift register that steps forward on an increment and backward on a decrement. Each bucket also has its own zero detector. There is no central count store and no shared adder, so an update changes the addressed register in place in a single clock. The actual count value never leaves the array; only the zero/non-zero answer is reported.

Buckets are grouped into partitions of equal size. The address is split into a partition index (upper bits) and a row index inside the partition (lower bits). Each partition drives one shared "row is empty" line for its addressed row, and a second-level selector picks the line of the addressed partition. A decrement aimed at an empty bucket is refused and flagged. A parameter chooses between a stored per-row empty flag and a plain comparator on the register state.

Top module: `lfsr_cbf`

## Requirements
- R1: After reset every bucket is empty: `is_zero` reads 1, `dec_err` reads 0, and a probe of any address returns 1.
- R2: A PROBE presented in cycle n sets `is_zero` at the clock edge that ends cycle n. `is_zero` is 1 exactly when the addressed bucket holds a zero count.
- R3: INC and DEC take effect at the clock edge that ends the request cycle. A bucket that received k increments reads empty again only after k decrements.
- R4: An update changes only the addressed bucket. Every other bucket keeps its count.
- R5: A DEC to an empty bucket leaves the bucket empty and raises `dec_err` for exactly the one cycle after the request.
- R6: `dec_err` is 0 in the cycle after any IDLE, INC, PROBE, or DEC to a non-empty bucket.
- R7: `is_zero` changes only after a PROBE. IDLE, INC and DEC leave it holding the last probe result.
- R8: Operation encoding on `op`: 2'b00 IDLE, 2'b01 INC, 2'b10 DEC, 2'b11 PROBE. The upper address bits select the partition and the lower log2(ROWS_PER_PART) bits select the row. Rows on either side of a partition boundary are independent.
- R9: `rst` is synchronous and active high. Asserting it in the middle of traffic empties every bucket at the next edge.
- R10: Parameter ZERO_FLAG selects a stored per-row empty flag (1) or a state comparator (0), with identical port behaviour. Elaboration rejects an entry count that is not a power of two, fewer than two rows per partition, fewer than two partitions, and an unsupported counter width (4, 8, 16 and 32 are supported).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties all buckets |
| op | input | 2 | Operation: 00 idle, 01 increment, 10 decrement, 11 probe |
| addr | input | log2(NUM_ENTRIES) | Bucket address: partition index in upper bits, row in lower bits |
| is_zero | output | 1 | Registered probe result, 1 when the probed bucket is empty |
| dec_err | output | 1 | One-cycle pulse after a decrement refused on an empty bucket |

## Verification
The hardest state to reach is an underflow attempt on a bucket that has a non-trivial history. The bench raises a bucket several steps, walks it back down to empty, and then issues one extra decrement. It then confirms that a single increment makes the bucket non-empty and a single decrement empties it again. This shows that the refused step never moved the register. Partition boundaries are reached by loading the last row of one partition and the first row of the next and probing both, plus their empty neighbours. A long pseudo-random mix of operations over all buckets is compared every cycle against an integer count model. A mid-traffic reset follows.

// File: rtl/lcbf_pkg.sv
package lcbf_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_INC   = 2'b01,
      OP_DEC   = 2'b10,
      OP_PROBE = 2'b11
   } cbf_op_e;

   // Fibonacci feedback mask (MSB always set) for a maximal-length
   // XNOR shift register of the given width; zero means unsupported.
   function automatic logic [31:0] lfsr_taps(input int unsigned w);
      case (w)
         4:       return 32'h0000_000C;
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_D008;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/cbf_lfsr_row.sv
module cbf_lfsr_row
   import lcbf_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter bit          ZERO_FLAG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic step_en,
   input  logic step_up,
   output logic row_empty
);

   localparam logic [31:0]      TAPS_FULL = lfsr_taps(CNT_W);
   localparam logic [CNT_W-1:0] TAPS      = TAPS_FULL[CNT_W-1:0];
   localparam logic [CNT_W-1:0] EMPTY_PAT = '0;

   logic [CNT_W-1:0] st_q;
   logic [CNT_W-1:0] st_fwd;
   logic [CNT_W-1:0] st_bwd;
   logic [CNT_W-1:0] st_d;

   // forward: shift toward MSB, new LSB from XNOR of tapped bits
   assign st_fwd = {st_q[CNT_W-2:0], ~^(st_q & TAPS)};
   // backward: exact inverse of the forward step
   assign st_bwd = {~(st_q[0] ^ (^(st_q[CNT_W-1:1] & TAPS[CNT_W-2:0]))),
                    st_q[CNT_W-1:1]};
   assign st_d   = step_up ? st_fwd : st_bwd;

   always_ff @(posedge clk) begin
      if (rst)          st_q <= EMPTY_PAT;
      else if (step_en) st_q <= st_d;
   end

   generate
      if (ZERO_FLAG) begin : g_flag
         logic zf_q;
         always_ff @(posedge clk) begin
            if (rst)          zf_q <= 1'b1;
            else if (step_en) zf_q <= (st_d == EMPTY_PAT);
         end
         assign row_empty = zf_q;

         // R10: the stored flag always mirrors the register contents
         a_r10_flag_tracks: assert property (@(posedge clk) disable iff (rst)
            zf_q == (st_q == EMPTY_PAT));
      end else begin : g_cmp
         assign row_empty = (st_q == EMPTY_PAT);
      end
   endgenerate

   // R1 / R9: reset leaves the row in its empty pattern
   a_r9_reset_empty: assert property (@(posedge clk)
      rst |=> (st_q == EMPTY_PAT));

   // R4: an unselected row keeps its state
   a_r4_row_holds: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(st_q));

endmodule

// File: rtl/cbf_partition.sv
module cbf_partition
   import lcbf_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ROWS      = 64,
   parameter bit          ZERO_FLAG = 1'b1,
   localparam int unsigned LAW      = $clog2(ROWS)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           part_upd,
   input  logic           step_up,
   input  logic [LAW-1:0] row_idx,
   output logic           part_empty
);

   logic [ROWS-1:0] row_en;
   logic [ROWS-1:0] row_empty_v;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign row_en[r] = part_upd && (row_idx == LAW'(r));

         cbf_lfsr_row #(
            .CNT_W    (CNT_W),
            .ZERO_FLAG(ZERO_FLAG)
         ) u_row (
            .clk      (clk),
            .rst      (rst),
            .step_en  (row_en[r]),
            .step_up  (step_up),
            .row_empty(row_empty_v[r])
         );
      end
   endgenerate

   // shared partition line: empty indication of the locally selected row
   assign part_empty = row_empty_v[row_idx];

   // R4: at most one row of the partition steps in a cycle
   a_r4_one_row: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_en));

endmodule

// File: rtl/lfsr_cbf.sv
module lfsr_cbf
   import lcbf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES   = 1024,
   parameter int unsigned ROWS_PER_PART = 64,
   parameter int unsigned CNT_W         = 16,
   parameter bit          ZERO_FLAG     = 1'b1,
   localparam int unsigned AW           = $clog2(NUM_ENTRIES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    op,
   input  logic [AW-1:0] addr,
   output logic          is_zero,
   output logic          dec_err
);

   localparam int unsigned NPART = NUM_ENTRIES / ROWS_PER_PART;
   localparam int unsigned LAW   = $clog2(ROWS_PER_PART);
   localparam int unsigned PAW   = AW - LAW;

   // R10: elaboration-time parameter checks
   generate
      if ((NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("NUM_ENTRIES must be a power of two");
      end
      if (ROWS_PER_PART < 2 || (NUM_ENTRIES % ROWS_PER_PART) != 0) begin : g_bad_rows
         $error("ROWS_PER_PART must be at least 2 and divide NUM_ENTRIES");
      end
      if (NPART < 2) begin : g_bad_parts
         $error("at least two partitions are required");
      end
      if (lfsr_taps(CNT_W) == 32'h0) begin : g_bad_width
         $error("CNT_W must be 4, 8, 16 or 32");
      end
   endgenerate

   cbf_op_e          op_e;
   logic [PAW-1:0]   part_idx;
   logic [LAW-1:0]   row_idx;
   logic [NPART-1:0] part_line;
   logic [NPART-1:0] part_en;
   logic             sel_empty;
   logic             do_step;
   logic             step_up;
   logic             zero_q;
   logic             err_q;

   assign op_e     = cbf_op_e'(op);
   assign part_idx = addr[AW-1:LAW];
   assign row_idx  = addr[LAW-1:0];

   // second-level selection of the addressed partition's empty line
   assign sel_empty = part_line[part_idx];

   // decrement of an empty bucket is refused
   assign step_up = (op_e == OP_INC);
   assign do_step = step_up || ((op_e == OP_DEC) && !sel_empty);

   generate
      for (genvar p = 0; p < NPART; p++) begin : g_part
         assign part_en[p] = do_step && (part_idx == PAW'(p));

         cbf_partition #(
            .CNT_W    (CNT_W),
            .ROWS     (ROWS_PER_PART),
            .ZERO_FLAG(ZERO_FLAG)
         ) u_part (
            .clk       (clk),
            .rst       (rst),
            .part_upd  (part_en[p]),
            .step_up   (step_up),
            .row_idx   (row_idx),
            .part_empty(part_line[p])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         zero_q <= 1'b1;
         err_q  <= 1'b0;
      end else begin
         if (op_e == OP_PROBE) zero_q <= sel_empty;
         err_q <= (op_e == OP_DEC) && sel_empty;
      end
   end

   assign is_zero = zero_q;
   assign dec_err = err_q;

   // R4: only one partition receives an update per cycle
   a_r4_one_part: assert property (@(posedge clk) disable iff (rst)
      $onehot0(part_en));

   // R5 / R6: an error pulse follows only a decrement
   a_r6_err_only_dec: assert property (@(posedge clk) disable iff (rst)
      (op_e != OP_DEC) |=> !dec_err);

   // R5: a refused decrement moves no partition
   a_r5_no_step_on_err: assert property (@(posedge clk) disable iff (rst)
      ((op_e == OP_DEC) && sel_empty) |-> (part_en == '0));

   // R7: the probe result holds when no probe was issued
   a_r7_zero_holds: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(op) != OP_PROBE)) |-> $stable(is_zero));

endmodule

// File: tb/tb_lfsr_cbf.sv
module tb_lfsr_cbf;
   import lcbf_pkg::*;

   localparam int N  = 32;
   localparam int RP = 8;
   localparam int W  = 8;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    op  = 2'b00;
   logic [AW-1:0] addr = '0;
   logic          is_zero;
   logic          dec_err;

   int total = 0;
   int bad   = 0;
   int cnt[N];
   bit exp_zero = 1'b1;
   bit exp_err  = 1'b0;
   bit done     = 1'b0;
   int unsigned seed = 32'h1234_5678;

   always #10 clk = ~clk;

   lfsr_cbf #(
      .NUM_ENTRIES  (N),
      .ROWS_PER_PART(RP),
      .CNT_W        (W),
      .ZERO_FLAG    (1'b1)   // R10 stored-flag variant
   ) dut (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .addr   (addr),
      .is_zero(is_zero),
      .dec_err(dec_err)
   );

   task automatic check(input string tag);
      total++;
      if (is_zero !== exp_zero) begin
         bad++;
         $display("FAIL %s is_zero actual=%0b expected=%0b", tag, is_zero, exp_zero);
      end
      total++;
      if (dec_err !== exp_err) begin
         bad++;
         $display("FAIL %s dec_err actual=%0b expected=%0b", tag, dec_err, exp_err);
      end
   endtask

   // called at a falling edge; applies one operation and checks the result
   task automatic step(input logic [1:0] o, input int a, input string tag);
      op   = o;
      addr = AW'(a);
      exp_err = (o == 2'b10) && (cnt[a] == 0);
      if (o == 2'b11) exp_zero = (cnt[a] == 0);
      if (o == 2'b01) cnt[a]++;
      if (o == 2'b10 && cnt[a] > 0) cnt[a]--;
      @(posedge clk);
      @(negedge clk);
      op = 2'b00;
      check(tag);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      op  = 2'b00;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      foreach (cnt[i]) cnt[i] = 0;
      exp_zero = 1'b1;
      exp_err  = 1'b0;
      check(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      foreach (cnt[i]) cnt[i] = 0;
      @(negedge clk);
      do_reset("R1 reset state");
      for (int a = 0; a < N; a++) step(2'b11, a, "R1 probe after reset");

      // R2 / R3: raise one bucket, probe, walk it back down
      for (int k = 0; k < 3; k++) step(2'b01, 5, "R3 inc");
      step(2'b11, 5, "R2 probe nonzero");
      step(2'b11, 4, "R4 neighbour below");
      step(2'b11, 6, "R4 neighbour above");
      for (int k = 0; k < 3; k++) begin
         step(2'b10, 5, "R3 dec");
         step(2'b11, 5, "R3 probe while walking down");
      end

      // R5: refused decrement at empty, state must be untouched
      step(2'b10, 5, "R5 dec at empty");
      step(2'b11, 5, "R5 still empty");
      step(2'b01, 5, "R5 inc after refusal");
      step(2'b11, 5, "R5 one step up");
      step(2'b10, 5, "R6 dec nonzero no err");
      step(2'b11, 5, "R5 back to empty");

      // R7: probe result holds across non-probe operations
      step(2'b01, 9, "R7 inc");
      step(2'b11, 9, "R7 probe");
      step(2'b00, 9, "R7 idle holds");
      step(2'b10, 9, "R7 dec holds");
      step(2'b01, 3, "R7 inc holds");

      // R8: partition boundaries and the last entry
      step(2'b01, RP - 1, "R8 last row of partition 0");
      step(2'b11, RP,     "R8 first row of partition 1 empty");
      step(2'b11, RP - 1, "R8 boundary row set");
      step(2'b01, N - 1,  "R8 last entry inc");
      step(2'b11, N - 1,  "R8 last entry probe");
      step(2'b11, N - 2,  "R8 last entry neighbour");
      step(2'b11, 0,      "R8 entry zero");

      // R8 / R3 / R4 / R6: pseudo-random traffic against the count model
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] o;
         int a;
         seed = seed * 32'd1103515245 + 32'd12345;
         o = seed[17:16];
         a = int'(seed[26:22]) % N;
         if (o == 2'b01 && cnt[a] >= 200) o = 2'b11;
         step(o, a, "R8 random traffic");
      end

      // R9: reset in the middle of traffic
      step(2'b01, 12, "R9 load");
      step(2'b01, 20, "R9 load");
      do_reset("R9 mid-run reset");
      step(2'b11, 12, "R9 probe after reset");
      step(2'b11, 20, "R9 probe after reset");
      step(2'b10, 20, "R9 dec after reset");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule